// File: doc/BRIEF.md
# Multi-Pin GPIO Register Bank

This block is a register-mapped controller for a bank of general-purpose pins, 94 by default. It sits on a simple 32-bit bus. Each access takes one cycle and uses a byte address, a write strobe, write data and combinational read data. Two address regions are decoded:

- **Packed ownership words.** One bit per pin, 32 pins to a word. A 0 bit marks a pin as held by firmware; the bank only stores this value for software to read.
- **Per-pin configuration.** Each pin has a pair of 32-bit words, spaced 8 bytes apart. The first word holds mode, direction, output level, trigger selection and the read-only input level. The second word holds the input-sense disable bit and a stored weak-pull code.

Pin-driving logic acts only on pins placed in GPIO mode. Pin inputs pass through a two-flop synchronizer before they reach software or the interrupt logic. Gating by the sense-disable bit happens after the synchronizer.

One global word selects which of two host interrupt lines the whole bank uses. The trigger bits of every pin and its gated, synchronized input are brought out for a separate interrupt unit.

Top module: `gpio_regbank`

## Requirements
- R1: After reset, every configuration word 1 reads 0x0000_0004 (input direction, native mode, output level 0). Every configuration word 2 reads 0x0000_0004 (sensing off). `pin_oe`, `pin_out`, `pin_sense` and `host_line_sel` are all 0.
- R2: Configuration word 1 of pin n is at byte address 0x100+8n and configuration word 2 is at 0x104+8n. Ownership for pin n is bit n%32 of the word at 0x00+4·(n/32).
- R3: `pin_oe[n]` is 1 exactly when word 1 bit 0 (GPIO mode) is 1 and bit 2 (direction) is 0. `pin_out[n]` equals word 1 bit 31 when bit 0 is 1, and is 0 otherwise. A write takes effect on the outputs after the clock edge that captures it.
- R4: Word 1 bit 30 reads the pin input after two synchronizer flops. It is forced to 0 while word 2 bit 2 (sense disable) is 1. A pin change shows up after the second rising edge, not after the first.
- R5: Writes to word 1 bit 30 have no effect. Only bits 31, 4, 3, 2 and 0 of word 1 and bits 2:0 of word 2 are writable; all other bits read 0.
- R6: `trig_level[n]` follows word 1 bit 4 (1 selects level, 0 selects edge). `trig_invert[n]` follows word 1 bit 3.
- R7: `pin_sense[n]` carries the synchronized input of pin n to the interrupt logic. It is 0 while sensing is disabled.
- R8: The global word at 0x7C stores bit 0, which drives `host_line_sel`. Its other bits read 0.
- R9: Unmapped or misaligned addresses read 0, and writes to them change no state. Examples are 0x0C–0x78, configuration addresses for pins at or above NUM_PINS, and addresses with bits 1:0 non-zero.
- R10: The ownership words are writable and reset to the parameter OWN_RESET. Bits of the last word that map past NUM_PINS read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pin_in | input | NUM_PINS | Raw pin inputs |
| pin_out | output | NUM_PINS | Output level per pin |
| pin_oe | output | NUM_PINS | Output enable per pin |
| pin_sense | output | NUM_PINS | Synchronized, sense-gated input for the interrupt unit |
| trig_level | output | NUM_PINS | Trigger kind per pin (1 level, 0 edge) |
| trig_invert | output | NUM_PINS | Trigger polarity invert per pin |
| host_line_sel | output | 1 | Selects one of two host interrupt lines |

## Verification
The bench builds the block with the default 94 pins. This places the last pin in a partly filled third ownership word and puts its configuration pair at the top of the decoded range. The lowest address beyond that pair can therefore be probed as unmapped.

OWN_RESET is overridden to 0xA5A5_5A5A, a mixed pattern, so a wrong reset constant or a wrong tail mask on the last word shows up on readback. The input path is sampled cycle by cycle to pin the latency at exactly two edges.

// File: rtl/gpio_regbank_pkg.sv
package gpio_regbank_pkg;

   localparam int WORD_W     = 32;
   localparam int CFG_BASE   = 'h100;
   localparam int CFG_STRIDE = 8;
   localparam int GLOB_OFF   = 'h7C;

   // field positions inside configuration word 1
   localparam int C1_OUT  = 31;
   localparam int C1_IN   = 30;
   localparam int C1_TLVL = 4;
   localparam int C1_TINV = 3;
   localparam int C1_DIR  = 2;
   localparam int C1_MODE = 0;

   // field positions inside configuration word 2
   localparam int C2_NOSNS = 2;
   localparam int C2_PULL  = 0;

   typedef struct packed {
      logic out_lvl;
      logic trig_lvl;
      logic trig_inv;
      logic dir_in;
      logic gpio_mode;
   } cfg1_t;

   typedef struct packed {
      logic       no_sense;
      logic [1:0] pull;
   } cfg2_t;

   localparam cfg1_t CFG1_RST = '{out_lvl: 1'b0, trig_lvl: 1'b0, trig_inv: 1'b0,
                                  dir_in: 1'b1, gpio_mode: 1'b0};
   localparam cfg2_t CFG2_RST = '{no_sense: 1'b1, pull: 2'b00};

   function automatic cfg1_t cfg1_from_word(input logic [WORD_W-1:0] w);
      cfg1_t c;
      c.out_lvl   = w[C1_OUT];
      c.trig_lvl  = w[C1_TLVL];
      c.trig_inv  = w[C1_TINV];
      c.dir_in    = w[C1_DIR];
      c.gpio_mode = w[C1_MODE];
      return c;
   endfunction

   function automatic cfg2_t cfg2_from_word(input logic [WORD_W-1:0] w);
      cfg2_t c;
      c.no_sense = w[C2_NOSNS];
      c.pull     = w[C2_PULL +: 2];
      return c;
   endfunction

   function automatic logic [WORD_W-1:0] cfg1_to_word(input cfg1_t c, input logic in_lvl);
      logic [WORD_W-1:0] w;
      w          = '0;
      w[C1_OUT]  = c.out_lvl;
      w[C1_IN]   = in_lvl;
      w[C1_TLVL] = c.trig_lvl;
      w[C1_TINV] = c.trig_inv;
      w[C1_DIR]  = c.dir_in;
      w[C1_MODE] = c.gpio_mode;
      return w;
   endfunction

   function automatic logic [WORD_W-1:0] cfg2_to_word(input cfg2_t c);
      logic [WORD_W-1:0] w;
      w               = '0;
      w[C2_NOSNS]     = c.no_sense;
      w[C2_PULL +: 2] = c.pull;
      return w;
   endfunction

endpackage

// File: rtl/gpio_regbank_sync.sv
module gpio_regbank_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gpio_regbank_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] stage_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= d_async;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_regbank_dec.sv
module gpio_regbank_dec
   import gpio_regbank_pkg::*;
#(
   parameter int NUM_PINS  = 94,
   parameter int ADDR_W    = 12,
   parameter int OWN_WORDS = (NUM_PINS + WORD_W - 1) / WORD_W,
   parameter int OWN_IDX_W = (OWN_WORDS > 1) ? $clog2(OWN_WORDS) : 1,
   parameter int PIN_IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
   input  logic [ADDR_W-1:0]    addr,
   output logic                 hit_own,
   output logic [OWN_IDX_W-1:0] own_idx,
   output logic                 hit_glob,
   output logic                 hit_cfg1,
   output logic                 hit_cfg2,
   output logic [PIN_IDX_W-1:0] pin_idx
);

   localparam int CFG_END = CFG_BASE + CFG_STRIDE * NUM_PINS;
   localparam logic [ADDR_W-1:0] OWN_END_A  = ADDR_W'(OWN_WORDS * 4);
   localparam logic [ADDR_W-1:0] GLOB_A     = ADDR_W'(GLOB_OFF);
   localparam logic [ADDR_W-1:0] CFG_BASE_A = ADDR_W'(CFG_BASE);
   localparam logic [ADDR_W-1:0] CFG_END_A  = ADDR_W'(CFG_END);

   logic              aligned;
   logic              in_cfg;
   logic [ADDR_W-1:0] cfg_off;

   always_comb begin
      aligned  = (addr[1:0] == 2'b00);
      hit_own  = aligned && (addr < OWN_END_A);
      own_idx  = OWN_IDX_W'(addr >> 2);
      hit_glob = (addr == GLOB_A);
      cfg_off  = addr - CFG_BASE_A;
      in_cfg   = aligned && (addr >= CFG_BASE_A) && (addr < CFG_END_A);
      hit_cfg1 = in_cfg && !cfg_off[2];
      hit_cfg2 = in_cfg &&  cfg_off[2];
      pin_idx  = PIN_IDX_W'(cfg_off >> 3);
   end

endmodule

// File: rtl/gpio_regbank_pin.sv
module gpio_regbank_pin
   import gpio_regbank_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_c1,
   input  logic              wr_c2,
   input  cfg1_t             new_c1,
   input  cfg2_t             new_c2,
   input  logic              in_sync,
   output logic [WORD_W-1:0] c1_word,
   output logic [WORD_W-1:0] c2_word,
   output logic              drv_out,
   output logic              drv_oe,
   output logic              sensed,
   output logic              trig_lvl,
   output logic              trig_inv
);

   cfg1_t c1_q;
   cfg2_t c2_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     c1_q <= CFG1_RST;
      else if (wr_c1) c1_q <= new_c1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     c2_q <= CFG2_RST;
      else if (wr_c2) c2_q <= new_c2;
   end

   always_comb begin
      sensed   = in_sync & ~c2_q.no_sense;
      drv_oe   = c1_q.gpio_mode & ~c1_q.dir_in;
      drv_out  = c1_q.gpio_mode &  c1_q.out_lvl;
      trig_lvl = c1_q.trig_lvl;
      trig_inv = c1_q.trig_inv;
      c1_word  = cfg1_to_word(c1_q, sensed);
      c2_word  = cfg2_to_word(c2_q);
   end

endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
   import gpio_regbank_pkg::*;
#(
   parameter int          NUM_PINS    = 94,
   parameter int          ADDR_W      = 12,
   parameter int          SYNC_STAGES = 2,
   parameter logic [31:0] OWN_RESET   = 32'hFFFF_FFFF
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_we,
   input  logic [31:0]         bus_wdata,
   output logic [31:0]         bus_rdata,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] pin_out,
   output logic [NUM_PINS-1:0] pin_oe,
   output logic [NUM_PINS-1:0] pin_sense,
   output logic [NUM_PINS-1:0] trig_level,
   output logic [NUM_PINS-1:0] trig_invert,
   output logic                host_line_sel
);

   localparam int OWN_WORDS = (NUM_PINS + WORD_W - 1) / WORD_W;
   localparam int OWN_IDX_W = (OWN_WORDS > 1) ? $clog2(OWN_WORDS) : 1;
   localparam int PIN_IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
   localparam int CFG_END   = CFG_BASE + CFG_STRIDE * NUM_PINS;

   generate
      if (NUM_PINS < 1) begin : g_bad_pins
         $error("gpio_regbank: NUM_PINS must be positive");
      end
      if (OWN_WORDS * 4 > GLOB_OFF) begin : g_bad_own
         $error("gpio_regbank: ownership words overlap the global word");
      end
      if (ADDR_W > 31 || CFG_END > (1 << ADDR_W)) begin : g_bad_addr
         $error("gpio_regbank: ADDR_W too small for the configuration region");
      end
   endgenerate

   // address decode
   logic                 hit_own, hit_glob, hit_cfg1, hit_cfg2;
   logic [OWN_IDX_W-1:0] own_idx;
   logic [PIN_IDX_W-1:0] pin_idx;

   gpio_regbank_dec #(
      .NUM_PINS (NUM_PINS),
      .ADDR_W   (ADDR_W),
      .OWN_WORDS(OWN_WORDS),
      .OWN_IDX_W(OWN_IDX_W),
      .PIN_IDX_W(PIN_IDX_W)
   ) u_dec (
      .addr    (bus_addr),
      .hit_own (hit_own),
      .own_idx (own_idx),
      .hit_glob(hit_glob),
      .hit_cfg1(hit_cfg1),
      .hit_cfg2(hit_cfg2),
      .pin_idx (pin_idx)
   );

   // input synchronizer
   logic [NUM_PINS-1:0] in_sync;

   gpio_regbank_sync #(
      .WIDTH (NUM_PINS),
      .STAGES(SYNC_STAGES)
   ) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_async(pin_in),
      .q_sync (in_sync)
   );

   // write data split into configuration fields once for all pins
   cfg1_t new_c1;
   cfg2_t new_c2;

   always_comb begin
      new_c1 = cfg1_from_word(bus_wdata);
      new_c2 = cfg2_from_word(bus_wdata);
   end

   // per-pin configuration cells
   logic [WORD_W-1:0] c1_words [NUM_PINS];
   logic [WORD_W-1:0] c2_words [NUM_PINS];

   generate
      for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
         logic sel_p;
         assign sel_p = (pin_idx == PIN_IDX_W'(p));

         gpio_regbank_pin u_pin (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_c1   (bus_we && hit_cfg1 && sel_p),
            .wr_c2   (bus_we && hit_cfg2 && sel_p),
            .new_c1  (new_c1),
            .new_c2  (new_c2),
            .in_sync (in_sync[p]),
            .c1_word (c1_words[p]),
            .c2_word (c2_words[p]),
            .drv_out (pin_out[p]),
            .drv_oe  (pin_oe[p]),
            .sensed  (pin_sense[p]),
            .trig_lvl(trig_level[p]),
            .trig_inv(trig_invert[p])
         );
      end
   endgenerate

   // ownership bitmap words; bits past the last pin are not stored
   logic [WORD_W-1:0] own_words [OWN_WORDS];

   generate
      for (genvar w = 0; w < OWN_WORDS; w++) begin : g_own
         localparam int VALID = ((NUM_PINS - w * WORD_W) >= WORD_W) ?
                                WORD_W : (NUM_PINS - w * WORD_W);
         localparam logic [WORD_W-1:0] MASK = (VALID == WORD_W) ? {WORD_W{1'b1}} :
                                              ((WORD_W'(1) << VALID) - WORD_W'(1));
         logic [WORD_W-1:0] own_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               own_q <= OWN_RESET & MASK;
            else if (bus_we && hit_own && (own_idx == OWN_IDX_W'(w)))
               own_q <= bus_wdata & MASK;
         end

         assign own_words[w] = own_q;
      end
   endgenerate

   // global interrupt line select
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 host_line_sel <= 1'b0;
      else if (bus_we && hit_glob) host_line_sel <= bus_wdata[0];
   end

   // read path
   always_comb begin
      bus_rdata = '0;
      if (hit_own)
         bus_rdata = own_words[own_idx];
      else if (hit_glob)
         bus_rdata = {{(WORD_W-1){1'b0}}, host_line_sel};
      else if (hit_cfg1)
         bus_rdata = c1_words[pin_idx];
      else if (hit_cfg2)
         bus_rdata = c2_words[pin_idx];
   end

endmodule

// File: rtl/gpio_regbank_chk.sv
module gpio_regbank_chk #(
   parameter int NUM_PINS = 94,
   parameter int ADDR_W   = 12
) (
   input logic                clk,
   input logic                rst_n,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic                bus_we,
   input logic [31:0]         bus_wdata,
   input logic [31:0]         bus_rdata,
   input logic [NUM_PINS-1:0] pin_in,
   input logic [NUM_PINS-1:0] pin_out,
   input logic [NUM_PINS-1:0] pin_oe,
   input logic [NUM_PINS-1:0] pin_sense,
   input logic [NUM_PINS-1:0] trig_level,
   input logic [NUM_PINS-1:0] trig_invert,
   input logic                host_line_sel
);

   localparam int OWN_WORDS = (NUM_PINS + 31) / 32;
   localparam int CFG_END   = 'h100 + 8 * NUM_PINS;

   int   a_int;
   int   w_pin;
   logic w_c1;
   logic gap_addr;

   always_comb begin
      a_int    = int'(bus_addr);
      w_pin    = (a_int - 'h100) / 8;
      w_c1     = (a_int >= 'h100) && (a_int < CFG_END) && (a_int % 8 == 0);
      gap_addr = (a_int >= OWN_WORDS * 4) && (a_int < 'h7C);
   end

   // R3: a write leaving GPIO mode releases the output enable
   a_r3_native_no_oe: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && w_c1 && !bus_wdata[0]) |=> !pin_oe[$past(w_pin)]);

   // R3: a GPIO-mode output write drives the pin with the written level
   a_r3_gpio_drives: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && w_c1 && bus_wdata[0] && !bus_wdata[2]) |=>
         (pin_oe[$past(w_pin)] && (pin_out[$past(w_pin)] == $past(bus_wdata[31]))));

   // R4 R7: a sensed high needs a high input two edges earlier
   a_r4_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
      ((pin_sense & ~$past(pin_in, 2)) == '0));

   // R6: trigger kind follows the last word-1 write
   a_r6_trig_follow: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && w_c1) |=> ((trig_level[$past(w_pin)] == $past(bus_wdata[4])) &&
                            (trig_invert[$past(w_pin)] == $past(bus_wdata[3]))));

   // R8: global word write sets the host line select
   a_r8_line_sel: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && (a_int == 'h7C)) |=> (host_line_sel == $past(bus_wdata[0])));

   // R9: the gap between ownership words and the global word reads 0
   a_r9_gap_zero: assert property (@(posedge clk) disable iff (!rst_n)
      gap_addr |-> (bus_rdata == '0));

endmodule

bind gpio_regbank gpio_regbank_chk #(
   .NUM_PINS(NUM_PINS),
   .ADDR_W  (ADDR_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_addr     (bus_addr),
   .bus_we       (bus_we),
   .bus_wdata    (bus_wdata),
   .bus_rdata    (bus_rdata),
   .pin_in       (pin_in),
   .pin_out      (pin_out),
   .pin_oe       (pin_oe),
   .pin_sense    (pin_sense),
   .trig_level   (trig_level),
   .trig_invert  (trig_invert),
   .host_line_sel(host_line_sel)
);

// File: tb/gpio_regbank_bench.sv
`timescale 1ns/1ps
module gpio_regbank_bench;

   localparam int NP = 94;
   localparam int AW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_we = 1'b0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NP-1:0] pin_in = '0;
   logic [NP-1:0] pin_out, pin_oe, pin_sense, trig_level, trig_invert;
   logic          host_line_sel;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   gpio_regbank #(
      .NUM_PINS (NP),
      .ADDR_W   (AW),
      .OWN_RESET(32'hA5A5_5A5A)
   ) u_gpio_regbank (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus_addr     (bus_addr),
      .bus_we       (bus_we),
      .bus_wdata    (bus_wdata),
      .bus_rdata    (bus_rdata),
      .pin_in       (pin_in),
      .pin_out      (pin_out),
      .pin_oe       (pin_oe),
      .pin_sense    (pin_sense),
      .trig_level   (trig_level),
      .trig_invert  (trig_invert),
      .host_line_sel(host_line_sel)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      bus_addr  = AW'(a);
      bus_wdata = d;
      bus_we    = 1'b1;
      @(negedge clk);
      bus_we    = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = AW'(a);
      #1;
      d = bus_rdata;
   endtask

   function automatic int c1a(input int n); return 'h100 + 8 * n; endfunction
   function automatic int c2a(input int n); return 'h104 + 8 * n; endfunction

   task automatic t_reset();
      logic [31:0] d;
      rd(c1a(0), d);  chk("R1 cfg1 pin0", d, 32'h0000_0004);
      rd(c1a(93), d); chk("R1 cfg1 pin93", d, 32'h0000_0004);
      rd(c2a(93), d); chk("R1 cfg2 pin93", d, 32'h0000_0004);
      chk("R1 oe", 32'(pin_oe != '0), 0);
      chk("R1 out", 32'(pin_out != '0), 0);
      chk("R1 sense", 32'(pin_sense != '0), 0);
      chk("R1 line sel", 32'(host_line_sel), 0);
      rd('h00, d); chk("R10 own word0 reset", d, 32'hA5A5_5A5A);
      rd('h08, d); chk("R10 own word2 reset masked", d, 32'h25A5_5A5A);
   endtask

   task automatic t_drive();
      logic [31:0] d;
      wr(c1a(5), 32'h8000_0001);
      #1;
      chk("R3 pin5 oe", 32'(pin_oe[5]), 1);
      chk("R3 pin5 out", 32'(pin_out[5]), 1);
      chk("R3 only pin5 driven", 32'(pin_oe), 32'h0000_0020);
      rd(c1a(5), d); chk("R2 pin5 cfg1 readback", d, 32'h8000_0001);
      wr(c1a(5), 32'h8000_0000);
      #1;
      chk("R3 native no oe", 32'(pin_oe[5]), 0);
      chk("R3 native no out", 32'(pin_out[5]), 0);
      wr(c1a(93), 32'h8000_0005);
      #1;
      chk("R3 pin93 input no oe", 32'(pin_oe[93]), 0);
      chk("R3 pin93 out level", 32'(pin_out[93]), 1);
   endtask

   task automatic t_input();
      logic [31:0] d;
      wr(c2a(40), 32'h0000_0000);
      @(negedge clk);
      pin_in[40] = 1'b1;
      @(negedge clk); #1;
      chk("R4 not after one edge", 32'(pin_sense[40]), 0);
      @(negedge clk); #1;
      chk("R4 R7 visible after two edges", 32'(pin_sense[40]), 1);
      rd(c1a(40), d); chk("R4 input level read", d, 32'h4000_0004);
      wr(c2a(40), 32'h0000_0004);
      #1;
      chk("R7 sense gated off", 32'(pin_sense[40]), 0);
      rd(c1a(40), d); chk("R4 level gated off", d, 32'h0000_0004);
      pin_in[40] = 1'b0;
   endtask

   task automatic t_fields();
      logic [31:0] d;
      repeat (3) @(negedge clk);
      wr(c1a(40), 32'hFFFF_FFFF);
      rd(c1a(40), d); chk("R5 cfg1 writable bits only", d, 32'h8000_001D);
      chk("R6 trig level set", 32'(trig_level[40]), 1);
      chk("R6 trig invert set", 32'(trig_invert[40]), 1);
      wr(c2a(40), 32'hFFFF_FFFF);
      rd(c2a(40), d); chk("R5 cfg2 writable bits only", d, 32'h0000_0007);
      wr(c1a(40), 32'h0000_0010);
      #1;
      chk("R6 trig level kept", 32'(trig_level[40]), 1);
      chk("R6 trig invert cleared", 32'(trig_invert[40]), 0);
   endtask

   task automatic t_glob();
      logic [31:0] d;
      wr('h7C, 32'hFFFF_FFFF);
      rd('h7C, d); chk("R8 global readback", d, 32'h0000_0001);
      chk("R8 line sel", 32'(host_line_sel), 1);
   endtask

   task automatic t_unmapped();
      logic [31:0] d;
      wr('h0C, 32'hFFFF_FFFF);
      rd('h0C, d); chk("R9 gap reads zero", d, 0);
      wr(c1a(94), 32'hFFFF_FFFF);
      rd(c1a(94), d); chk("R9 past last pin reads zero", d, 0);
      wr('h101, 32'hFFFF_FFFF);
      rd('h101, d); chk("R9 misaligned reads zero", d, 0);
      rd(c1a(0), d); chk("R9 misaligned write ignored", d, 32'h0000_0004);
      chk("R9 no pin driven by stray writes", 32'(pin_oe[0]), 0);
   endtask

   task automatic t_own();
      logic [31:0] d;
      wr('h04, 32'h1234_5678);
      rd('h04, d); chk("R10 own word1 write", d, 32'h1234_5678);
      wr('h08, 32'hFFFF_FFFF);
      rd('h08, d); chk("R10 R2 own word2 tail masked", d, 32'h3FFF_FFFF);
      rd('h00, d); chk("R2 own word0 untouched", d, 32'hA5A5_5A5A);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_drive();
      t_input();
      t_fields();
      t_glob();
      t_unmapped();
      t_own();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

endmodule